// File: doc/BRIEF.md
# Serial Character Transmitter with Queue

This block turns bytes written by a host into asynchronous serial frames on a single output line. A frame opens with a low start bit, carries 5 to 8 data bits with the lowest bit first, may add a parity bit, and closes with one or two high stop bits. Bit timing is taken from an external baud-tick strobe. Each bit lasts 16, 8 or 4 ticks, as chosen by a mode field.

Bytes wait in a 32-entry queue. The queue can be cut down to a single holding slot for one-character-at-a-time operation. Two status outputs report the state of the path. One says that nothing is waiting to be sent. The other says that the whole path, including the frame on the line, has gone quiet. An interrupt reports that the queue has drained below a selectable fill threshold and, later, that it has emptied. A flow-control gate can hold back new frames while the far end is not ready.

Top module: `sertx_top`

## Requirements
- R1: Each frame is a 0 start bit, then `word_len+5` data bits sent lowest bit first (`word_len` 0 to 3), then the optional parity bit, then the stop bit(s) at 1. Bytes leave in the order they were written.
- R2: When `par_en` is 1, a parity bit follows the data. With `par_even`=1 it makes the count of ones over the data and parity even. With `par_even`=0 it makes that count odd.
- R3: `two_stop`=1 gives two stop bits and 0 gives one. A frame lasts exactly (1 + data bits + parity bit + stop bits) × bit-length ticks, counted from the cycle its start bit appears.
- R4: `os_sel` picks the bit length in baud ticks: 0 gives 16, 1 gives 8, 2 gives 4, and 3 is treated as 16. Framing is correct whether ticks arrive every cycle or more sparsely.
- R5: With `fifo_mode`=1, up to 32 bytes are queued. A write that finds the queue full is dropped and leaves the stored bytes untouched.
- R6: With `fifo_mode`=0, a single holding slot is used. A write while that slot is occupied is dropped.
- R7: `hold_empty` is 1 when no byte is waiting. In single-slot mode it rises in the cycle the byte moves into the shifter. In queue mode it rises when the queue becomes empty.
- R8: `shift_empty` is 1 only when no byte is waiting and no frame is on the line.
- R9: An interrupt becomes pending when the queue fill falls from the threshold to below it (queue mode only), and again whenever the queue or holding slot becomes empty. Threshold codes on `trig_sel` are 0 for 8, 1 for 16, 2 for 24 and 3 for 30.
- R10: `tx_irq` shows the pending interrupt only while `irq_en` is 1. A pending interrupt is kept while it is masked.
- R11: A pulse on `status_rd`, or a host write, clears a pending interrupt. A new drain event in the same cycle wins.
- R12: With `cts_auto`=1 and `cts_ok`=0, no new frame starts, but a frame already begun completes normally. With `cts_auto`=0, `cts_ok` is ignored.
- R13: After reset and whenever no frame is being sent, `txd` is 1. Reset leaves `hold_empty`=1, `shift_empty`=1 and `tx_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Write strobe for one transmit byte |
| host_wdata | input | 8 | Byte to transmit |
| fifo_mode | input | 1 | 1: 32-entry queue, 0: single holding slot |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| os_sel | input | 2 | Baud ticks per bit: 0 for 16, 1 for 8, 2 for 4, 3 for 16 |
| trig_sel | input | 2 | Drain threshold: 0 for 8, 1 for 16, 2 for 24, 3 for 30 |
| irq_en | input | 1 | Interrupt output enable |
| status_rd | input | 1 | Interrupt status read pulse, clears pending |
| cts_auto | input | 1 | Enable the flow-control gate |
| cts_ok | input | 1 | Far end ready, 1 allows new frames |
| baud_tick | input | 1 | Baud-rate strobe, one cycle wide |
| txd | output | 1 | Serial output, idle 1 |
| hold_empty | output | 1 | No byte waiting |
| shift_empty | output | 1 | No byte waiting and line idle |
| tx_irq | output | 1 | Transmit-empty interrupt |

## Verification
The assertions take for granted that `fifo_mode` changes only while the path is fully empty, and that framing fields change only between frames. The block latches those fields when a frame starts, but a mode switch with bytes queued would break the fill bound. They also assume that a write and a shifter load never fall in the same cycle while the queue is full. The stimulus keeps to this: every configuration change is made only after `shift_empty` has been seen high. Overflow is provoked only while the flow-control gate holds the shifter still.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_phase_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       stop_two;
    logic [1:0] os_sel;
  } frame_cfg_t;

  // baud ticks that make up one bit on the line
  function automatic logic [4:0] ticks_per_bit(input logic [1:0] sel);
    case (sel)
      2'd1:    return 5'd8;
      2'd2:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // index of the final data bit for a word-length code
  function automatic logic [2:0] last_data_idx(input logic [1:0] wlen);
    return 3'd4 + {1'b0, wlen};
  endfunction

  function automatic logic frame_parity(input logic [7:0] d, input logic [1:0] wlen,
                                        input logic even);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (3'(i) <= last_data_idx(wlen)) acc = acc ^ d[i];
    end
    return even ? acc : ~acc;
  endfunction

  // drain threshold for a code, scaled to the queue depth
  function automatic int unsigned trig_fill(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (3 * depth) / 4;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop,
  input  logic             single_slot,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    level,
  output logic             push_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    cap;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap     = single_slot ? CW'(1) : CW'(DEPTH);
  assign push_ok = push_req && (cnt < cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop)     rp <= bump(rp);
      cnt <= cnt + CW'(push_ok) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign level = cnt;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       start_req,
  input  logic [7:0] din,
  input  frame_cfg_t cfg_in,
  output logic       txd,
  output logic       busy,
  output logic       load,
  output logic       frame_done
);

  tx_phase_e  phase;
  frame_cfg_t cfg_q;
  logic [7:0] data_q;
  logic [2:0] idx;
  logic [3:0] tcnt;
  logic       bit_end;

  assign busy       = (phase != TX_IDLE);
  assign load       = (phase == TX_IDLE) && start_req;
  assign bit_end    = busy && baud_tick &&
                      ({1'b0, tcnt} == ticks_per_bit(cfg_q.os_sel) - 5'd1);
  assign frame_done = bit_end && (phase == TX_STOP) && (!cfg_q.stop_two || idx == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= TX_IDLE;
      cfg_q  <= '0;
      data_q <= '0;
      idx    <= '0;
      tcnt   <= '0;
      txd    <= 1'b1;
    end else if (load) begin
      phase  <= TX_START;
      cfg_q  <= cfg_in;
      data_q <= din;
      idx    <= '0;
      tcnt   <= '0;
      txd    <= 1'b0;
    end else if (busy && baud_tick) begin
      if (!bit_end) begin
        tcnt <= tcnt + 4'd1;
      end else begin
        tcnt <= '0;
        case (phase)
          TX_START: begin
            phase <= TX_DATA;
            idx   <= '0;
            txd   <= data_q[0];
          end
          TX_DATA: begin
            if (idx == last_data_idx(cfg_q.wlen)) begin
              idx <= '0;
              if (cfg_q.par_en) begin
                phase <= TX_PAR;
                txd   <= frame_parity(data_q, cfg_q.wlen, cfg_q.par_even);
              end else begin
                phase <= TX_STOP;
                txd   <= 1'b1;
              end
            end else begin
              idx <= idx + 3'd1;
              txd <= data_q[idx + 3'd1];
            end
          end
          TX_PAR: begin
            phase <= TX_STOP;
            idx   <= '0;
            txd   <= 1'b1;
          end
          TX_STOP: begin
            if (frame_done) phase <= TX_IDLE;
            else            idx   <= idx + 3'd1;
            txd <= 1'b1;
          end
          default: begin
            phase <= TX_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
  import sertx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic          push_ok,
  input  logic          pop,
  input  logic          fifo_mode,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  input  logic          status_rd,
  input  logic          host_wr,
  output logic          irq,
  output logic          irq_pend,
  output logic          irq_set
);

  logic [CW-1:0] level_nxt;
  logic [CW-1:0] trig;
  logic          crossed;
  logic          drained;

  assign level_nxt = level + CW'(push_ok) - CW'(pop);
  assign trig      = CW'(trig_fill(trig_sel, DEPTH));
  assign crossed   = fifo_mode && (level >= trig) && (level_nxt < trig);
  assign drained   = (level != '0) && (level_nxt == '0);
  assign irq_set   = crossed || drained;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq_pend <= 1'b0;
    else if (irq_set)                irq_pend <= 1'b1;
    else if (status_rd || host_wr)   irq_pend <= 1'b0;
  end

  assign irq = irq_pend && irq_en;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       fifo_mode,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic [1:0] os_sel,
  input  logic [1:0] trig_sel,
  input  logic       irq_en,
  input  logic       status_rd,
  input  logic       cts_auto,
  input  logic       cts_ok,
  input  logic       baud_tick,
  output logic       txd,
  output logic       hold_empty,
  output logic       shift_empty,
  output logic       tx_irq
);

  logic [7:0]    head_w;
  logic [CW-1:0] level_w;
  logic          push_ok_w;
  logic          load_w;
  logic          busy_w;
  logic          frame_done_w;
  logic          gate_open_w;
  logic          irq_pend_w;
  logic          irq_set_w;
  frame_cfg_t    cfg_w;

  assign cfg_w = '{wlen: word_len, par_en: par_en, par_even: par_even,
                   stop_two: two_stop, os_sel: os_sel};
  assign gate_open_w = !cts_auto || cts_ok;

  sertx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (host_wr),
    .pop        (load_w),
    .single_slot(!fifo_mode),
    .din        (host_wdata),
    .dout       (head_w),
    .level      (level_w),
    .push_ok    (push_ok_w)
  );

  sertx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .start_req ((level_w != '0) && gate_open_w),
    .din       (head_w),
    .cfg_in    (cfg_w),
    .txd       (txd),
    .busy      (busy_w),
    .load      (load_w),
    .frame_done(frame_done_w)
  );

  sertx_irq #(.DEPTH(DEPTH), .CW(CW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level_w),
    .push_ok  (push_ok_w),
    .pop      (load_w),
    .fifo_mode(fifo_mode),
    .trig_sel (trig_sel),
    .irq_en   (irq_en),
    .status_rd(status_rd),
    .host_wr  (host_wr),
    .irq      (tx_irq),
    .irq_pend (irq_pend_w),
    .irq_set  (irq_set_w)
  );

  assign hold_empty  = (level_w == '0);
  assign shift_empty = hold_empty && !busy_w;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          status_rd,
  input logic          cts_auto,
  input logic          cts_ok,
  input logic          fifo_mode,
  input logic          txd,
  input logic          hold_empty,
  input logic          shift_empty,
  input logic          busy,
  input logic          load,
  input logic          frame_done,
  input logic [CW-1:0] level,
  input logic          push_ok,
  input logic          irq_pend,
  input logic          irq_set
);

  assert_idle_mark_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!txd && busy));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (fifo_mode ? CW'(DEPTH) : CW'(1)));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !push_ok && !load) |=> (level == $past(level)));

  assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (txd && (!busy || $past(load))));

  assert_cts_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto && !cts_ok && !busy) |=> !busy);

  assert_set_needs_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> load);

  assert_rd_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !irq_set) |=> !irq_pend);

  assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> (txd && hold_empty));

endmodule

bind sertx_top sertx_checker #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .status_rd  (status_rd),
  .cts_auto   (cts_auto),
  .cts_ok     (cts_ok),
  .fifo_mode  (fifo_mode),
  .txd        (txd),
  .hold_empty (hold_empty),
  .shift_empty(shift_empty),
  .busy       (busy_w),
  .load       (load_w),
  .frame_done (frame_done_w),
  .level      (level_w),
  .push_ok    (push_ok_w),
  .irq_pend   (irq_pend_w),
  .irq_set    (irq_set_w)
);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       fifo_mode = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       two_stop = 1'b0;
  logic [1:0] os_sel = 2'd2;
  logic [1:0] trig_sel = 2'd0;
  logic       irq_en = 1'b0;
  logic       status_rd = 1'b0;
  logic       cts_auto = 1'b0;
  logic       cts_ok = 1'b1;
  logic       baud_tick = 1'b1;
  logic       txd, hold_empty, shift_empty, tx_irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tick_per = 1;
  int tdiv = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sertx_top dut_i (.*);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tick_per <= 1) baud_tick <= 1'b1;
    else begin
      tdiv = (tdiv + 1) % tick_per;
      baud_tick <= (tdiv == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  logic [7:0] r_data;
  logic r_par, r_stop_ok, r_start_ok, r_irq, r_he, r_se;
  int r_t0;

  task automatic rx_frame(input int nbits, input bit pen, input int nstop, input int len);
    int w = 0;
    do begin @(negedge clk); w++; end while (txd !== 1'b0 && w < 6000);
    if (w >= 6000) begin
      chk(0, "R1 start bit timeout", 1, 0);
      return;
    end
    r_t0 = cyc; r_irq = tx_irq; r_he = hold_empty; r_se = shift_empty;
    repeat (len / 2) @(negedge clk);
    r_start_ok = (txd == 1'b0);
    r_data = '0;
    for (int k = 0; k < nbits; k++) begin
      repeat (len) @(negedge clk);
      r_data[k] = txd;
    end
    r_par = 1'b0;
    if (pen) begin
      repeat (len) @(negedge clk);
      r_par = txd;
    end
    r_stop_ok = 1'b1;
    for (int s = 0; s < nstop; s++) begin
      repeat (len) @(negedge clk);
      if (txd !== 1'b1) r_stop_ok = 1'b0;
    end
  endtask

  task automatic wait_quiet();
    int w = 0;
    while (!shift_empty && w < 8000) begin @(negedge clk); w++; end
  endtask

  function automatic int os_len(input int sel);
    return (sel == 1) ? 8 : (sel == 2) ? 4 : 16;
  endfunction

  // stays idle-high for n cycles, returns 1 if so
  task automatic watch_idle(input int n, output bit ok);
    ok = 1;
    repeat (n) begin @(negedge clk); if (txd !== 1'b1) ok = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(txd == 1'b1, "R13 reset txd", txd, 1);
    chk(hold_empty == 1'b1, "R13 reset hold_empty", hold_empty, 1);
    chk(shift_empty == 1'b1, "R13 reset shift_empty", shift_empty, 1);
    chk(tx_irq == 1'b0, "R13 reset irq", tx_irq, 0);

    // R1 R2 R3 R4 sweep over every framing option, ticks every cycle
    for (int osi = 0; osi < 3; osi++)
      for (int wl = 0; wl < 4; wl++)
        for (int pm = 0; pm < 3; pm++)
          for (int st = 0; st < 2; st++) begin
            int nb, len, bits, ones;
            logic [7:0] d, dm;
            logic pexp;
            nb = 5 + wl; len = os_len(osi);
            bits = 1 + nb + ((pm != 0) ? 1 : 0) + st + 1;
            d = 8'(37 * (osi * 24 + wl * 6 + pm * 2 + st) + 8'h5A);
            dm = d & 8'((1 << nb) - 1);
            ones = 0;
            for (int i = 0; i < nb; i++) ones += d[i];
            pexp = (pm == 1) ? ((ones % 2) == 1) : ((ones % 2) == 0);
            @(negedge clk);
            os_sel = 2'(osi); word_len = 2'(wl); par_en = (pm != 0);
            par_even = (pm == 1); two_stop = (st == 1);
            wr(d);
            rx_frame(nb, pm != 0, st + 1, len);
            chk(r_start_ok, "R1 start bit low", r_start_ok, 1);
            chk(r_data == dm, "R1 data bits", r_data, dm);
            if (pm != 0) chk(r_par == pexp, "R2 parity bit", r_par, pexp);
            chk(r_stop_ok, "R3 stop bits high", r_stop_ok, 1);
            wait_quiet();
            chk(cyc - r_t0 == bits * len, "R3 R4 frame length", cyc - r_t0, bits * len);
          end

    // R4 sparse ticks: one tick every third cycle
    tick_per = 3;
    for (int osi = 0; osi < 4; osi++) begin
      logic [7:0] d;
      int len;
      d = 8'(8'hC6 + osi * 29);
      len = os_len(osi) * 3;
      @(negedge clk);
      os_sel = 2'(osi); word_len = 2'd3; par_en = 0; two_stop = 0;
      wr(d);
      rx_frame(8, 0, 1, len);
      chk(r_data == d && r_stop_ok, "R4 sparse tick frame", r_data, d);
      wait_quiet();
    end
    tick_per = 1;
    @(negedge clk);
    os_sel = 2'd2; word_len = 2'd3; par_en = 0; two_stop = 0;

    // R5 queue depth, order and overflow drop
    cts_auto = 1; cts_ok = 0; fifo_mode = 1;
    for (int i = 0; i < 34; i++) wr(8'(i * 7 + 3));
    @(negedge clk); cts_ok = 1;
    for (int k = 0; k < 32; k++) begin
      rx_frame(8, 0, 1, 4);
      chk(r_data == 8'(k * 7 + 3), "R5 queued byte order", r_data, 8'(k * 7 + 3));
    end
    watch_idle(80, ok);
    chk(ok, "R5 overflow bytes dropped", ok, 1);
    chk(shift_empty, "R8 quiet after drain", shift_empty, 1);

    // R12 flow-control gate
    cts_ok = 0;
    wr(8'h3C); wr(8'hC3);
    watch_idle(60, ok);
    chk(ok, "R12 gate holds frame", ok, 1);
    chk(hold_empty == 0, "R7 byte still waiting", hold_empty, 0);
    @(negedge clk); cts_ok = 1;
    fork
      rx_frame(8, 0, 1, 4);
      begin repeat (3) @(negedge clk); cts_ok = 0; end
    join
    chk(r_data == 8'h3C && r_stop_ok, "R12 frame in flight completes", r_data, 8'h3C);
    watch_idle(60, ok);
    chk(ok, "R12 next frame held", ok, 1);
    @(negedge clk); cts_auto = 0;
    rx_frame(8, 0, 1, 4);
    chk(r_data == 8'hC3, "R12 gate ignored when disabled", r_data, 8'hC3);
    wait_quiet();

    // R6 R7 R8 R9 R11 single holding slot
    @(negedge clk); fifo_mode = 0; cts_auto = 1; cts_ok = 0; irq_en = 1;
    wr(8'hA5);
    chk(hold_empty == 0, "R7 slot occupied", hold_empty, 0);
    chk(shift_empty == 0, "R8 not quiet with byte", shift_empty, 0);
    wr(8'h5A);
    @(negedge clk); cts_ok = 1;
    rx_frame(8, 0, 1, 4);
    chk(r_he == 1, "R7 empty on move to shifter", r_he, 1);
    chk(r_se == 0, "R8 not quiet during frame", r_se, 0);
    chk(r_irq == 1, "R9 slot drained interrupt", r_irq, 1);
    chk(r_data == 8'hA5, "R6 first byte sent", r_data, 8'hA5);
    wait_quiet();
    watch_idle(60, ok);
    chk(ok, "R6 second write dropped", ok, 1);
    chk(tx_irq == 1, "R10 pending held", tx_irq, 1);
    @(negedge clk); cts_ok = 0;
    wr(8'h11);
    chk(tx_irq == 0, "R11 write clears", tx_irq, 0);
    @(negedge clk); cts_ok = 1;
    rx_frame(8, 0, 1, 4);
    chk(r_irq == 1, "R9 slot drained again", r_irq, 1);
    rd_status();
    chk(tx_irq == 0, "R11 status read clears", tx_irq, 0);
    wait_quiet();

    // R9 R10 R11 R7 drain threshold per code
    @(negedge clk); fifo_mode = 1;
    for (int sel = 0; sel < 4; sel++) begin
      int trig, n;
      bit exp;
      trig = (sel < 3) ? 8 * (sel + 1) : 30;
      n = trig + 2;
      @(negedge clk); trig_sel = 2'(sel); irq_en = (sel != 0); cts_ok = 0;
      for (int i = 0; i < n; i++) wr(8'(i + sel * 40));
      @(negedge clk); cts_ok = 1;
      for (int k = 1; k <= n; k++) begin
        rx_frame(8, 0, 1, 4);
        exp = (sel != 0) && (k == 3 || k == n);
        chk(r_irq == exp, "R9 threshold interrupt", r_irq, exp);
        if (k == n - 1) chk(r_he == 0, "R7 queue not empty", r_he, 0);
        if (k == n)     chk(r_he == 1, "R7 queue empty", r_he, 1);
        if (exp) begin
          rd_status();
          chk(tx_irq == 0, "R11 read clears threshold", tx_irq, 0);
        end
      end
      wait_quiet();
      if (sel == 0) begin
        chk(tx_irq == 0, "R10 masked output low", tx_irq, 0);
        @(negedge clk); irq_en = 1;
        @(negedge clk);
        chk(tx_irq == 1, "R10 masked pending kept", tx_irq, 1);
        rd_status();
      end
    end

    chk(txd == 1'b1, "R13 idle line high", txd, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule